// File: doc/BRIEF.md
# External Bus Hand-Off Controller

This block decides when a processor's external memory bus may be handed to another bus master. An outside device raises a request. The controller answers with a registered grant, but only at a boundary between external accesses. An access already on the bus always finishes first. When a single instruction makes two external accesses, the hand-off can fall between them, so the grant never waits for the instruction to complete. While the grant is high, the memory interface drivers are switched off.

The core reports two things to the controller. One is a level that says an external access is waiting to begin. The other is a strobe that marks the last cycle of the access now on the bus. A mode input sets what the core does while the bus is away. In the default mode the core is held as soon as the grant rises. In run-on mode the core keeps executing internal work, and it is held only when it needs the bus. A separate hung flag marks that case. The request path never stops working, and it answers requests even while reset is asserted. For debug, an emulator-enable input replaces the reset, the request and the grant with a second set of pins, and it switches off the normal grant pin's driver.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: A request seen while an external access is in flight produces no grant, and no driver release, before the cycle after the one in which `acc_done` is high.
- R2: When a second access is pending behind the first, the grant rises in the cycle after the first access's `acc_done`, and the second access does not start while the grant is high.
- R3: With `go_mode` low, `core_stall` is high in every cycle in which the grant is high.
- R4: With `go_mode` high and the grant high, `core_stall` stays low until `acc_pend` is high. From then on, `core_stall` and `grant_hung` are both high until the grant falls.
- R5: After the request falls, the grant falls and `mem_drv_en` returns high in the same cycle. `grant_hung` and `core_stall` drop in that cycle too, and the waiting access starts at the next clock edge.
- R6: Requests are answered while the selected reset is low: the grant follows the request with the normal latency.
- R7: With `emu_en` high, `emu_rst_n` and `emu_bus_req` replace `rst_n` and `bus_req`, `bus_grant_oe` is low, and `emu_bus_grant` carries the grant. The normal request and the normal reset then have no effect.
- R8: The request passes through a two-flop synchronizer. The grant is high from the third clock edge after the request rises, and `mem_drv_en` is low in exactly the cycles in which the grant is high.
- R9: With `emu_en` low, `emu_bus_grant` is low and `emu_bus_req` has no effect. `bus_grant_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Normal core reset, active low, synchronous |
| emu_en | input | 1 | Selects the emulator pin set |
| emu_rst_n | input | 1 | Emulator core reset, active low |
| bus_req | input | 1 | Normal bus request from the external master, asynchronous |
| emu_bus_req | input | 1 | Emulator bus request, asynchronous |
| acc_pend | input | 1 | Core has an external access waiting to start |
| acc_done | input | 1 | Last cycle of the access now on the bus |
| go_mode | input | 1 | 1: core keeps running while the bus is granted |
| bus_grant | output | 1 | Normal grant value |
| bus_grant_oe | output | 1 | Output enable of the normal grant pin |
| emu_bus_grant | output | 1 | Emulator grant |
| grant_hung | output | 1 | Core needs the bus but the bus is granted away |
| core_stall | output | 1 | Holds the core |
| mem_drv_en | output | 1 | Memory interface drivers enabled (low = high impedance) |

## Verification
The bench raises a request in the middle of an access and holds `acc_done` back. A design that grants on the raw request would take the bus away from a transfer that is still in progress. The bench then requests during a two-access instruction and looks for a grant between the two accesses. A design that waits for the whole instruction would show the grant too late. A design that lets the second access start anyway would never show the hung flag. Run-on mode is checked both for a needless stall and for a missing hung flag. After the release, a second request must wait behind the resumed access, which shows that the access really restarted. The remaining checks cover requests during reset and the emulator pin swap, where the normal pins must stop acting.

// File: rtl/bh_pkg.sv
// Shared types and defaults for the bus hand-off controller.
// Assumes: nothing beyond IEEE 1800-2017.
package bh_pkg;

    // Which master owns the external memory bus.
    typedef enum logic {
        OWN_CORE = 1'b0,
        OWN_EXT  = 1'b1
    } bus_owner_e;

    // Minimum depth of the request synchronizer.
    localparam int unsigned BH_MIN_SYNC = 2;

endpackage

// File: rtl/bh_sync.sv
// Multi-flop synchronizer for a single asynchronous level.
// Assumes: STAGES >= 2. Not reset on purpose, so requests pass during reset.
module bh_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) chain[0] <= din;
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[LAST];

endmodule

// File: rtl/bh_pin_swap.sv
// Selects between the normal and emulator reset/request/grant pins.
// Assumes: emu_en is static or changes only while no request is active.
module bh_pin_swap (
    input  logic emu_en,
    input  logic rst_n,
    input  logic emu_rst_n,
    input  logic bus_req,
    input  logic emu_bus_req,
    input  logic grant,
    output logic rst_sel_n,
    output logic req_sel,
    output logic bus_grant,
    output logic bus_grant_oe,
    output logic emu_bus_grant
);
    // Input selection: the emulator set replaces the normal set.
    always_comb begin
        rst_sel_n = emu_en ? emu_rst_n   : rst_n;
        req_sel   = emu_en ? emu_bus_req : bus_req;
    end

    // Output routing: the normal grant pin is released to high impedance in emulation.
    always_comb begin
        bus_grant     = grant;
        bus_grant_oe  = ~emu_en;
        emu_bus_grant = emu_en & grant;
    end

endmodule

// File: rtl/bh_arbiter.sv
// Grant decision, access tracking and core stall for the bus hand-off.
// Assumes: req_s is already synchronized. acc_done is only meaningful
// while an access is in flight. An access starts on a clock edge where
// acc_pend is high and the bus is owned by the core.
module bh_arbiter
    import bh_pkg::*;
(
    input  logic clk,
    input  logic run_n,
    input  logic req_s,
    input  logic acc_pend,
    input  logic acc_done,
    input  logic go_mode,
    output logic grant,
    output logic hung,
    output logic stall,
    output logic mem_drv_en
);
    bus_owner_e owner_q, owner_d;
    logic       in_flight_q;
    logic       grant_set;
    logic       acc_start;
    logic       blocked;

    // Grant may rise only when no access holds the bus past this cycle.
    always_comb begin
        grant_set = req_s && (owner_q == OWN_CORE) && (!in_flight_q || acc_done);
    end

    // A waiting access starts only if the bus stays with the core.
    always_comb begin
        acc_start = run_n && acc_pend && (owner_q == OWN_CORE) && !in_flight_q && !grant_set;
    end

    // Next owner: grant on a boundary, release as soon as the request drops.
    always_comb begin
        owner_d = owner_q;
        if (owner_q == OWN_CORE) begin
            if (grant_set) owner_d = OWN_EXT;
        end else if (!req_s) begin
            owner_d = OWN_CORE;
        end
    end

    // Owner register; deliberately outside reset so requests are served in reset.
    always_ff @(posedge clk) owner_q <= owner_d;

    // Tracks whether an external access currently holds the bus.
    always_ff @(posedge clk) begin
        if (!run_n)                       in_flight_q <= 1'b0;
        else if (acc_start)               in_flight_q <= 1'b1;
        else if (in_flight_q && acc_done) in_flight_q <= 1'b0;
    end

    // Core wants the bus but cannot have it this cycle.
    always_comb begin
        blocked = run_n && acc_pend && !in_flight_q && ((owner_q == OWN_EXT) || grant_set);
    end

    // Outputs derived from ownership and the blocked condition.
    always_comb begin
        grant      = (owner_q == OWN_EXT);
        mem_drv_en = (owner_q == OWN_CORE);
        hung       = blocked && (owner_q == OWN_EXT);
        stall      = (!go_mode && (owner_q == OWN_EXT)) || blocked;
    end

    AST_NO_GRANT_MID_ACCESS: assert property (@(posedge clk) disable iff (!run_n)
        (in_flight_q && !acc_done && !grant) |=> !grant); // R1

    AST_GRANT_BETWEEN_ACCESSES: assert property (@(posedge clk) disable iff (!run_n)
        (in_flight_q && acc_done && req_s && !grant) |=> grant); // R2

    AST_RUNON_NO_STALL: assert property (@(posedge clk) disable iff (!run_n)
        (go_mode && grant && !acc_pend) |-> !stall); // R4

    AST_HUNG_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!run_n)
        (acc_pend && !in_flight_q && grant) |-> (hung && stall)); // R4

    AST_RELEASE_ON_DROP: assert property (@(posedge clk) disable iff (!run_n)
        (grant && !req_s) |=> !grant); // R5

endmodule

// File: rtl/bus_handoff_ctrl.sv
// Top of the external bus hand-off controller: pin swap, request
// synchronizer and grant arbiter.
// Assumes: bus_req/emu_bus_req are asynchronous levels; all core-side
// strobes are synchronous to clk.
module bus_handoff_ctrl #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic emu_en,
    input  logic emu_rst_n,
    input  logic bus_req,
    input  logic emu_bus_req,
    input  logic acc_pend,
    input  logic acc_done,
    input  logic go_mode,
    output logic bus_grant,
    output logic bus_grant_oe,
    output logic emu_bus_grant,
    output logic grant_hung,
    output logic core_stall,
    output logic mem_drv_en
);
    import bh_pkg::*;

    localparam int unsigned STAGES = (SYNC_STAGES < BH_MIN_SYNC) ? BH_MIN_SYNC : SYNC_STAGES;

    logic rst_sel_n;
    logic req_sel;
    logic req_s;
    logic grant;

    bh_pin_swap u_swap (
        .emu_en        (emu_en),
        .rst_n         (rst_n),
        .emu_rst_n     (emu_rst_n),
        .bus_req       (bus_req),
        .emu_bus_req   (emu_bus_req),
        .grant         (grant),
        .rst_sel_n     (rst_sel_n),
        .req_sel       (req_sel),
        .bus_grant     (bus_grant),
        .bus_grant_oe  (bus_grant_oe),
        .emu_bus_grant (emu_bus_grant)
    );

    bh_sync #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .din  (req_sel),
        .dout (req_s)
    );

    bh_arbiter u_arb (
        .clk        (clk),
        .run_n      (rst_sel_n),
        .req_s      (req_s),
        .acc_pend   (acc_pend),
        .acc_done   (acc_done),
        .go_mode    (go_mode),
        .grant      (grant),
        .hung       (grant_hung),
        .stall      (core_stall),
        .mem_drv_en (mem_drv_en)
    );

    AST_DRIVERS_OFF_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rst_sel_n)
        (grant != mem_drv_en)); // R8

    AST_STALL_WHEN_GRANTED: assert property (@(posedge clk) disable iff (!rst_sel_n)
        (!go_mode && bus_grant) |-> core_stall); // R3

endmodule

// File: tb/bus_handoff_ctrl_bench.sv
// Scoreboard bench: the driver pushes expected port values for given cycles,
// and a monitor pops and compares them at the falling edge.
module bus_handoff_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0, emu_en = 1'b0, emu_rst_n = 1'b0;
    logic bus_req = 1'b0, emu_bus_req = 1'b0;
    logic acc_pend = 1'b0, acc_done = 1'b0, go_mode = 1'b0;
    logic bus_grant, bus_grant_oe, emu_bus_grant, grant_hung, core_stall, mem_drv_en;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    typedef struct {
        int    at;
        logic  g, drv, st, hg, oe, eg;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk; // 125 MHz

    bus_handoff_ctrl u_bus_handoff_ctrl (
        .clk(clk), .rst_n(rst_n), .emu_en(emu_en), .emu_rst_n(emu_rst_n),
        .bus_req(bus_req), .emu_bus_req(emu_bus_req), .acc_pend(acc_pend),
        .acc_done(acc_done), .go_mode(go_mode), .bus_grant(bus_grant),
        .bus_grant_oe(bus_grant_oe), .emu_bus_grant(emu_bus_grant),
        .grant_hung(grant_hung), .core_stall(core_stall), .mem_drv_en(mem_drv_en)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Wait until cycle t has begun, then step past the edge.
    task automatic at(input int t);
        while (cyc < t) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Push an expectation. Driver enable, pin enable and emulator grant follow from R7, R8 and R9.
    task automatic ex(input int t, input logic g, input logic st, input logic hg, input string tag);
        exp_t e;
        e.at = t; e.g = g; e.drv = ~g; e.st = st; e.hg = hg;
        e.oe = ~emu_en; e.eg = emu_en & g; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares the outputs against every expectation due this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (e.at != cyc || bus_grant !== e.g || mem_drv_en !== e.drv || core_stall !== e.st ||
                grant_hung !== e.hg || bus_grant_oe !== e.oe || emu_bus_grant !== e.eg) begin
                n_fail++;
                $display("FAIL %s cyc=%0d act g=%b drv=%b st=%b hg=%b oe=%b eg=%b exp@%0d g=%b drv=%b st=%b hg=%b oe=%b eg=%b",
                         e.tag, cyc, bus_grant, mem_drv_en, core_stall, grant_hung, bus_grant_oe,
                         emu_bus_grant, e.at, e.g, e.drv, e.st, e.hg, e.oe, e.eg);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #40000;
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog cyc=%0d act running exp finished", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset state and a request during reset (R6, R8)
        at(4);  ex(4, 0, 0, 0, "R6 reset state");
        at(6);  bus_req = 1'b1;
                ex(8, 0, 0, 0, "R8 no grant before second sync edge");
                ex(9, 1, 1, 0, "R6 R8 grant during reset");
        at(10); bus_req = 1'b0;
                ex(12, 1, 1, 0, "R5 grant held until sync");
                ex(13, 0, 0, 0, "R6 release during reset");
        at(16); rst_n = 1'b1;

        // Request arrives mid-access (R1, R3, R5)
        at(20); acc_pend = 1'b1;
        at(21); acc_pend = 1'b0; bus_req = 1'b1;
                ex(24, 0, 0, 0, "R1 no grant while access in flight");
                ex(25, 0, 0, 0, "R1 no grant in done cycle");
        at(25); acc_done = 1'b1;
                ex(26, 1, 1, 0, "R1 R3 grant after done, core stalled");
        at(26); acc_done = 1'b0; bus_req = 1'b0;
                ex(28, 1, 1, 0, "R3 stall while granted");
                ex(29, 0, 0, 0, "R5 release restores drivers");

        // Two-access instruction (R2, R5)
        at(35); acc_pend = 1'b1;
        at(36); bus_req = 1'b1;
                ex(38, 0, 0, 0, "R2 no grant during first access");
        at(38); acc_done = 1'b1;
                ex(39, 1, 1, 1, "R2 grant between accesses");
        at(39); acc_done = 1'b0; bus_req = 1'b0;
                ex(41, 1, 1, 1, "R2 second access held");
                ex(42, 0, 0, 0, "R5 hung and stall drop on release");
        at(42); bus_req = 1'b1;
        at(43); acc_pend = 1'b0;
                ex(45, 0, 0, 0, "R5 resumed access holds off new grant");
        at(46); acc_done = 1'b1;
                ex(47, 1, 1, 0, "R1 grant after resumed access");
        at(47); acc_done = 1'b0; bus_req = 1'b0;
                ex(50, 0, 0, 0, "R5 release");

        // Run-on mode (R4, R5)
        at(55); go_mode = 1'b1; bus_req = 1'b1;
                ex(58, 1, 0, 0, "R4 granted but core runs");
        at(59); acc_pend = 1'b1;
                ex(59, 1, 1, 1, "R4 hung when access needed");
        at(60); bus_req = 1'b0;
                ex(62, 1, 1, 1, "R4 hung held");
                ex(63, 0, 0, 0, "R5 hung drops");
        at(64); acc_pend = 1'b0; acc_done = 1'b1;
        at(65); acc_done = 1'b0; go_mode = 1'b0;

        // Emulator pin swap (R7)
        at(70); emu_en = 1'b1; emu_rst_n = 1'b1; rst_n = 1'b0; bus_req = 1'b1;
                ex(70, 0, 0, 0, "R7 normal grant pin released");
                ex(74, 0, 0, 0, "R7 normal request ignored");
        at(74); emu_bus_req = 1'b1;
                ex(77, 1, 1, 0, "R7 emulator grant");
        at(78); acc_pend = 1'b1;
                ex(78, 1, 1, 1, "R7 normal reset ignored");
        at(79); emu_bus_req = 1'b0;
                ex(82, 0, 0, 0, "R7 emulator release");
        at(83); acc_pend = 1'b0; acc_done = 1'b1; bus_req = 1'b0;
        at(84); acc_done = 1'b0;

        // Emulator request ignored in normal mode (R9)
        at(86); emu_en = 1'b0; rst_n = 1'b1; emu_bus_req = 1'b1;
                ex(90, 0, 0, 0, "R9 emulator request ignored");
        at(91); emu_bus_req = 1'b0;

        at(95);
        while (sb.size() > 0) begin
            @(posedge clk);
            #1;
        end
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule